// File: doc/BRIEF.md
# ROM Mirror Size Detector

This block works out whether an attached ROM holds 1 MB, 2 MB or 4 MB of distinct data. A smaller ROM on a 22-bit address space repeats its own image higher up. The block looks for that repeat. It reads the first 64 bytes of the ROM and compares each one with the byte at the same offset plus 1 MB and plus 2 MB. Only the first 64 offsets are read, so detection costs at most 192 reads and never a full pass over the device.

The block is a read-only bus master. It raises a request with an address and holds both until the memory side returns one cycle of acknowledge with the data byte, and it never has more than one read in flight. A one-cycle start pulse begins a scan. When the scan ends, the block raises a done level and a two-bit size code, and both stay put until the next start. Each of the two mirror candidates keeps its own match counter. Once a candidate has missed one byte it is no longer read, and the scan ends at once when both have missed.

Top module: `rom_size_detect`

## Requirements
- R1: After reset, rdReq and done are low and sizeCode reads 2 (4 MB).
- R2: A start pulse while idle or done begins a new scan: done falls at the next clock edge, and the first read issued is address 0.
- R3: A raised rdReq stays high with an unchanged rdAddr until the cycle in which rdAck is seen, and only one read is outstanding at any time.
- R4: For each offset n from 0 upward, reads go in this order: the base byte at n, then n+0x100000 if that candidate is still alive, then n+0x200000 if that candidate is still alive.
- R5: Once a candidate has mismatched at some offset, no further reads go to its region, so the total read count equals the reads its live candidates require.
- R6: When neither candidate is alive at the start of an offset, the scan ends without reading that offset, and sizeCode is 2 (4 MB). sizeCode never takes the value 3.
- R7: If every one of the 64 bytes at +0x100000 matched the base bytes, sizeCode is 0 (1 MB), whatever the +0x200000 result.
- R8: If the 1 MB candidate failed but all 64 bytes at +0x200000 matched, sizeCode is 1 (2 MB).
- R9: While done is high, rdReq stays low and sizeCode is stable until the next start. A start pulse during a scan is ignored and leaves the read sequence unchanged.
- R10: Every requested address has an offset part (address modulo 0x100000) below 64 and lies below 0x200000+64.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that begins a scan |
| rdReq | output | 1 | Read request, held until acknowledged |
| rdAddr | output | 22 | Byte address of the pending read |
| rdAck | input | 1 | One-cycle acknowledge carrying rdData |
| rdData | input | 8 | Read data, valid with rdAck |
| done | output | 1 | Scan finished, result valid |
| sizeCode | output | 2 | 0 = 1 MB, 1 = 2 MB, 2 = 4 MB |

## Verification
The assertions assume the memory side gives rdAck only while rdReq is high, for exactly one cycle per request, and that start is a single-cycle pulse. The bench responder keeps to this. It waits for a visible request, holds acknowledge low for a random latency of 0 to 2 cycles, then raises acknowledge for one cycle with the data. Start pulses are driven for a single cycle only, including the mid-scan pulse that checks the pulse is ignored.

// File: rtl/rsd_pkg.sv
package rsd_pkg;

  typedef enum logic [1:0] {
    SIZE_1M = 2'd0,
    SIZE_2M = 2'd1,
    SIZE_4M = 2'd2
  } sizeCode_e;

  typedef enum logic [1:0] {
    SEL_BASE = 2'd0,
    SEL_LOW  = 2'd1,
    SEL_HIGH = 2'd2
  } rdSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   clearAll;
    logic   captureBase;
    logic   cmpLow;
    logic   cmpHigh;
    logic   stepOffset;
    logic   latchSize;
    rdSel_e rdSel;
  } ctrlStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic lowAlive;
    logic highAlive;
    logic windowEnd;
  } dpStatus_t;

endpackage

// File: rtl/rsd_dpath.sv
module rsd_dpath
  import rsd_pkg::*;
#(
  parameter int unsigned ADDR_W      = 22,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned WINDOW      = 64,
  parameter int unsigned LOW_MIRROR  = 32'h0010_0000,
  parameter int unsigned HIGH_MIRROR = 32'h0020_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] rdData,
  output dpStatus_t         status,
  output logic [ADDR_W-1:0] rdAddr,
  output sizeCode_e         sizeCode
);

  localparam int unsigned CNT_W = $clog2(WINDOW + 1);
  localparam logic [CNT_W-1:0] WIN_END = CNT_W'(WINDOW);

  logic [CNT_W-1:0]  offset;
  logic [CNT_W-1:0]  lowCnt;
  logic [CNT_W-1:0]  highCnt;
  logic [DATA_W-1:0] baseByte;
  sizeCode_e         sizeReg;
  logic              byteMatch;

  assign byteMatch = (rdData == baseByte);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      offset   <= '0;
      lowCnt   <= '0;
      highCnt  <= '0;
      baseByte <= '0;
      sizeReg  <= SIZE_4M;
    end else begin
      if (strobe.clearAll) begin
        offset  <= '0;
        lowCnt  <= '0;
        highCnt <= '0;
      end
      if (strobe.captureBase) baseByte <= rdData;
      if (strobe.cmpLow && byteMatch) lowCnt <= lowCnt + CNT_W'(1);
      if (strobe.cmpHigh && byteMatch) highCnt <= highCnt + CNT_W'(1);
      if (strobe.stepOffset) offset <= offset + CNT_W'(1);
      if (strobe.latchSize) begin
        if (lowCnt == WIN_END)       sizeReg <= SIZE_1M;
        else if (highCnt == WIN_END) sizeReg <= SIZE_2M;
        else                         sizeReg <= SIZE_4M;
      end
    end
  end

  // a candidate is alive while its match count keeps pace with the offset
  assign status.lowAlive  = (lowCnt == offset);
  assign status.highAlive = (highCnt == offset);
  assign status.windowEnd = (offset == WIN_END);

  logic [ADDR_W-1:0] offExt;
  assign offExt = ADDR_W'(offset);

  always_comb begin
    unique case (strobe.rdSel)
      SEL_LOW:  rdAddr = offExt + ADDR_W'(LOW_MIRROR);
      SEL_HIGH: rdAddr = offExt + ADDR_W'(HIGH_MIRROR);
      default:  rdAddr = offExt;
    endcase
  end

  assign sizeCode = sizeReg;

endmodule

// File: rtl/rsd_ctrl.sv
module rsd_ctrl
  import rsd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        rdAck,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output logic        rdReq,
  output logic        done
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_RD_BASE, ST_RD_LOW, ST_RD_HIGH, ST_DONE
  } state_e;

  state_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    strobe.rdSel = SEL_BASE;
    unique case (state)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          strobe.clearAll = 1'b1;
          nextState = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (status.windowEnd || (!status.lowAlive && !status.highAlive)) begin
          strobe.latchSize = 1'b1;
          nextState = ST_DONE;
        end else begin
          nextState = ST_RD_BASE;
        end
      end
      ST_RD_BASE: begin
        strobe.rdSel = SEL_BASE;
        if (rdAck) begin
          strobe.captureBase = 1'b1;
          nextState = status.lowAlive ? ST_RD_LOW : ST_RD_HIGH;
        end
      end
      ST_RD_LOW: begin
        strobe.rdSel = SEL_LOW;
        if (rdAck) begin
          strobe.cmpLow = 1'b1;
          if (status.highAlive) begin
            nextState = ST_RD_HIGH;
          end else begin
            strobe.stepOffset = 1'b1;
            nextState = ST_CHECK;
          end
        end
      end
      ST_RD_HIGH: begin
        strobe.rdSel = SEL_HIGH;
        if (rdAck) begin
          strobe.cmpHigh    = 1'b1;
          strobe.stepOffset = 1'b1;
          nextState = ST_CHECK;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign rdReq = (state == ST_RD_BASE) || (state == ST_RD_LOW) || (state == ST_RD_HIGH);
  assign done  = (state == ST_DONE);

endmodule

// File: rtl/rom_size_detect.sv
module rom_size_detect
  import rsd_pkg::*;
#(
  parameter int unsigned ADDR_W      = 22,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned WINDOW      = 64,
  parameter int unsigned LOW_MIRROR  = 32'h0010_0000,
  parameter int unsigned HIGH_MIRROR = 32'h0020_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic              rdReq,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic              rdAck,
  input  logic [DATA_W-1:0] rdData,
  output logic              done,
  output logic [1:0]        sizeCode
);

  ctrlStrobe_t strobe;
  dpStatus_t   status;
  sizeCode_e   sizeEnum;

  rsd_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .rdAck  (rdAck),
    .status (status),
    .strobe (strobe),
    .rdReq  (rdReq),
    .done   (done)
  );

  rsd_dpath #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .WINDOW      (WINDOW),
    .LOW_MIRROR  (LOW_MIRROR),
    .HIGH_MIRROR (HIGH_MIRROR)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .rdData   (rdData),
    .status   (status),
    .rdAddr   (rdAddr),
    .sizeCode (sizeEnum)
  );

  assign sizeCode = sizeEnum;

endmodule

// File: rtl/rsd_checker.sv
module rsd_checker #(
  parameter int unsigned ADDR_W      = 22,
  parameter int unsigned WINDOW      = 64,
  parameter int unsigned LOW_MIRROR  = 32'h0010_0000,
  parameter int unsigned HIGH_MIRROR = 32'h0020_0000
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              rdReq,
  input logic [ADDR_W-1:0] rdAddr,
  input logic              rdAck,
  input logic              done,
  input logic [1:0]        sizeCode
);

  localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'(LOW_MIRROR - 1);
  localparam logic [ADDR_W-1:0] WIN_LIM  = ADDR_W'(WINDOW);
  localparam logic [ADDR_W-1:0] TOP_LIM  = ADDR_W'(HIGH_MIRROR + WINDOW);

  assert_hold_request_R3: assert property (@(posedge clk) disable iff (!rstN)
    rdReq && !rdAck |=> rdReq && $stable(rdAddr));

  assert_quiet_when_done_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !rdReq);

  assert_result_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    done && !start |=> done && $stable(sizeCode));

  assert_restart_clears_R2: assert property (@(posedge clk) disable iff (!rstN)
    start && done |=> !done);

  assert_offset_in_window_R10: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |-> ((rdAddr & OFF_MASK) < WIN_LIM) && (rdAddr < TOP_LIM));

  assert_legal_code_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> sizeCode != 2'd3);

endmodule

bind rom_size_detect rsd_checker #(
  .ADDR_W      (ADDR_W),
  .WINDOW      (WINDOW),
  .LOW_MIRROR  (LOW_MIRROR),
  .HIGH_MIRROR (HIGH_MIRROR)
) u_rsd_checker (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .rdReq    (rdReq),
  .rdAddr   (rdAddr),
  .rdAck    (rdAck),
  .done     (done),
  .sizeCode (sizeCode)
);

// File: tb/tb_rom_size_detect.sv
`timescale 1ns/1ps
module tb_rom_size_detect;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        rdReq;
  logic [21:0] rdAddr;
  logic        rdAck = 1'b0;
  logic [7:0]  rdData = 8'h00;
  logic        done;
  logic [1:0]  sizeCode;

  always #4 clk = ~clk;

  rom_size_detect dut (
    .clk(clk), .rstN(rstN), .start(start),
    .rdReq(rdReq), .rdAddr(rdAddr), .rdAck(rdAck), .rdData(rdData),
    .done(done), .sizeCode(sizeCode)
  );

  int checks = 0;
  int errors = 0;

  // ROM model: kind 0 = 1 MB image, 1 = 2 MB image, 2 = 4 MB distinct
  int romKind;
  int breakLow;
  int breakHigh;
  int romSeed;

  int expAddr [0:191];
  int expCount;
  int expCode;
  int reqIdx;
  int seqErr;

  function automatic logic [7:0] romByte(input int a);
    int m, t;
    logic [7:0] v;
    m = (romKind == 0) ? 32'h000F_FFFF : (romKind == 1) ? 32'h001F_FFFF : 32'h003F_FFFF;
    t = a & m;
    t = t ^ (t >> 9) ^ (t >> 17);
    v = 8'(t * 157) ^ 8'(t >> 8) ^ 8'(romSeed);
    if (breakLow >= 0 && a == 32'h0010_0000 + breakLow) v = v ^ 8'hA5;
    if (breakHigh >= 0 && a == 32'h0020_0000 + breakHigh) v = v ^ 8'h3C;
    return v;
  endfunction

  task automatic buildExpect();
    int lc, hc;
    logic [7:0] b;
    lc = 0; hc = 0; expCount = 0;
    for (int n = 0; n < 64; n++) begin
      if (lc != n && hc != n) break;
      b = romByte(n);
      expAddr[expCount] = n; expCount++;
      if (lc == n) begin
        expAddr[expCount] = 32'h0010_0000 + n; expCount++;
        if (romByte(32'h0010_0000 + n) == b) lc++;
      end
      if (hc == n) begin
        expAddr[expCount] = 32'h0020_0000 + n; expCount++;
        if (romByte(32'h0020_0000 + n) == b) hc++;
      end
    end
    expCode = (lc == 64) ? 0 : (hc == 64) ? 1 : 2;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // memory responder: one read at a time, random latency 0..2
  initial begin
    forever begin
      @(negedge clk);
      rdAck = 1'b0;
      if (rdReq && rstN) begin
        if (reqIdx >= 192 || int'(rdAddr) != expAddr[reqIdx]) seqErr++;
        reqIdx++;
        repeat ($urandom % 3) @(negedge clk);
        rdData = romByte(int'(rdAddr));
        rdAck = 1'b1;
      end
    end
  end

  task automatic runScan(input int kind, input int bl, input int bh, input int sd,
                         input bit pokeStart, input string codeReq);
    int wait_n;
    logic [1:0] heldCode;
    romKind = kind; breakLow = bl; breakHigh = bh; romSeed = sd;
    buildExpect();
    reqIdx = 0; seqErr = 0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b0, "R2 done falls after start", done, 0);
    if (pokeStart) begin
      repeat (20) @(negedge clk);
      if (!done) begin
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
    end
    wait_n = 0;
    while (!done && wait_n < 5000) begin
      @(negedge clk);
      wait_n++;
    end
    check(done == 1'b1, "R9 scan reaches done", done, 1);
    check(int'(sizeCode) == expCode, codeReq, sizeCode, expCode);
    check(seqErr == 0, "R4 read order", seqErr, 0);
    check(reqIdx == expCount, "R5 read count", reqIdx, expCount);
    heldCode = sizeCode;
    repeat (4) @(negedge clk);
    check(done && !rdReq && sizeCode == heldCode, "R9 result held", sizeCode, heldCode);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int k, bl, bh;
    string tag;
    void'($urandom(32'h5EED_0042));
    romKind = 2; breakLow = -1; breakHigh = -1; romSeed = 0;
    expCount = 0; reqIdx = 0; seqErr = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(rdReq == 1'b0 && done == 1'b0, "R1 reset outputs", {rdReq, done}, 0);
    check(sizeCode == 2'd2, "R1 reset code", sizeCode, 2);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(rdReq == 1'b0 && done == 1'b0, "R1 idle after reset", {rdReq, done}, 0);

    // directed corners
    runScan(0, -1, -1, 8'h11, 1'b0, "R7 clean 1 MB image");
    runScan(1, -1, -1, 8'h22, 1'b0, "R8 clean 2 MB image");
    runScan(2, -1, -1, 8'h33, 1'b0, "R6 distinct 4 MB image");
    runScan(0, 63, -1, 8'h44, 1'b0, "R8 1 MB miss at last byte");
    runScan(0, 0, 0, 8'h55, 1'b0, "R6 both miss at offset 0");
    runScan(1, -1, 63, 8'h66, 1'b1, "R6 2 MB miss at last byte");
    runScan(0, -1, 10, 8'h77, 1'b1, "R7 priority over 2 MB");

    // random scans
    for (int i = 0; i < 24; i++) begin
      k  = $urandom % 3;
      bl = ($urandom % 2) ? int'($urandom % 64) : -1;
      bh = ($urandom % 2) ? int'($urandom % 64) : -1;
      buildExpectTag(k, bl, bh, tag);
      runScan(k, bl, bh, int'($urandom % 256), ($urandom % 3) == 0, tag);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic buildExpectTag(input int k, input int bl, input int bh, output string tag);
    if (k == 0 && bl < 0)      tag = "R7 random size code";
    else if (k <= 1 && bh < 0) tag = "R8 random size code";
    else                       tag = "R6 random size code";
  endtask

endmodule